// File: doc/BRIEF.md
# Host bus byte-order adapter

This block sits between a 16-bit synchronous host bus and the 32-bit registers and FIFOs inside a network controller. Each 32-bit access arrives as two host halfword cycles. The halfword at the lower address (address bit 1 clear) comes first and the one at the upper address follows. On writes the adapter assembles the two halfwords into one word and issues a single internal write strobe. On reads it fetches the whole word on the first halfword, holds it, and returns the upper half from that hold on the second.

While a word passes through, the adapter can exchange its two halfwords and can reverse its four bytes. The halfword exchange is global and is set by a swap control register. Byte reversal applies only to data-FIFO traffic, and it depends on how the data FIFO was reached. Accesses in the low data-port address window use one endian bit. Accesses made with the FIFO-select input high use a second, independent bit. On writes the halfword exchange comes before the byte reversal. On reads the byte reversal comes first.

The adapter holds its own configuration word, which carries the two endian bits, and its own swap register. Accesses to either are served locally and are not forwarded to the internal bus.

Top module: `hbus_order_adapter`

## Requirements
- R1: A synchronous active-high reset clears both endian bits and the swap register, so swapping is off. It also discards a pending first halfword, so an upper-half write after reset produces no internal write.
- R2: A lower-half write (strobe, write, address bit 1 = 0) followed by an upper-half write makes `int_wr` pulse for exactly one cycle, in the cycle after the upper-half strobe. The write address is word-aligned. An upper-half write with no pending lower half produces no `int_wr`.
- R3: A lower-half read asserts `int_rd` in the same cycle, with a word-aligned `int_rd_addr`, and samples `int_rd_data`. `hb_rdata` is valid in the cycle after each strobe: the low half of the ordered word after the lower-half read, and the held high half after the upper-half read, even if `int_rd_data` has changed. An upper-half read does not assert `int_rd`.
- R4: The access class is encoded 0 = register, 1 = status FIFO, 2 = data FIFO by address, 3 = data FIFO by select. The decode order is: select input high gives 3; otherwise an address up to 0x3C gives 2; otherwise an address in 0x40..0x4C gives 1; anything else gives 0. The class is reported on `int_wr_cls` and `int_rd_cls`.
- R5: When an endian bit is 0 the word passes unchanged. When it is 1 the four bytes are reversed, so byte 3 moves to byte 0, byte 2 to byte 1, and so on.
- R6: Class 2 uses the port-endian bit (configuration bit 20). Class 3 uses the select-endian bit (configuration bit 21). Each bit acts without regard to the other.
- R7: Register and status-FIFO accesses never get byte reversal, whatever the endian bits hold.
- R8: The halfword exchange is active only while the swap register holds 0xFFFFFFFF. It then applies to every class, including reads and writes of the configuration word.
- R9: A write result is the endian reordering of the swapped host word. A read result is the swap of the endian-reordered internal word.
- R10: The configuration word sits at address 0x74 and the swap register at 0x98, both with the select input low. Both read back, and neither is forwarded to the internal bus. The swap register is always written and read with no swap and no byte reversal.
- R11: The class and the address are taken from the lower-half cycle. A change of the select input on the upper-half cycle does not alter the ordering or the class of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_strobe | input | 1 | One-cycle host halfword access strobe |
| hb_write | input | 1 | 1 = write, 0 = read |
| hb_fifo_sel | input | 1 | Data-FIFO select strobe, overrides the address decode |
| hb_addr | input | ADDR_W | Host byte address; bit 1 picks the halfword |
| hb_wdata | input | HALF_W | Host write halfword |
| hb_rdata | output | HALF_W | Host read halfword, registered |
| int_wr | output | 1 | Internal write pulse |
| int_wr_addr | output | ADDR_W | Word-aligned internal write address |
| int_wr_data | output | 2*HALF_W | Ordered internal write word |
| int_wr_cls | output | 2 | Class of the internal write |
| int_rd | output | 1 | Internal read request, same cycle as the lower-half read |
| int_rd_addr | output | ADDR_W | Word-aligned internal read address |
| int_rd_cls | output | 2 | Class of the internal read |
| int_rd_data | input | 2*HALF_W | Internal read word, valid while int_rd is high |

## Verification
The assertions assume that the host strobe lasts one cycle per halfword. They also assume that `hb_wdata` is stable on the upper-half cycle that completes a register or status write, and that the swap register is not rewritten in the same cycle as an internal write. The stimulus meets these conditions by construction. Every halfword is driven for exactly one clock between falling edges, and writes to the configuration and swap registers are whole, separate word accesses. Random register addresses are drawn from 0x50..0x6C, so they never hit the configuration or swap locations by accident.

// File: rtl/hbo_pkg.sv
package hbo_pkg;

   typedef enum logic [1:0] {
      CLS_CSR   = 2'd0,
      CLS_STS   = 2'd1,
      CLS_DPORT = 2'd2,
      CLS_DSEL  = 2'd3
   } acc_cls_t;

endpackage

// File: rtl/hbo_class_decode.sv
module hbo_class_decode
   import hbo_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DPORT_TOP = 'h3C,
   parameter int unsigned STS_LO    = 'h40,
   parameter int unsigned STS_HI    = 'h4C,
   parameter int unsigned CFG_ADDR  = 'h74,
   parameter int unsigned SWAP_ADDR = 'h98
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              fifo_sel_i,
   output acc_cls_t          cls_o,
   output logic              hit_cfg_o,
   output logic              hit_swap_o
);
   localparam logic [ADDR_W-1:0] A_DTOP = ADDR_W'(DPORT_TOP);
   localparam logic [ADDR_W-1:0] A_SLO  = ADDR_W'(STS_LO);
   localparam logic [ADDR_W-1:0] A_SHI  = ADDR_W'(STS_HI);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
   localparam logic [ADDR_W-1:0] A_SWAP = ADDR_W'(SWAP_ADDR);

   always_comb begin
      hit_cfg_o  = !fifo_sel_i && (addr_i == A_CFG);
      hit_swap_o = !fifo_sel_i && (addr_i == A_SWAP);
      if (fifo_sel_i)
         cls_o = CLS_DSEL;
      else if (addr_i <= A_DTOP)
         cls_o = CLS_DPORT;
      else if ((addr_i >= A_SLO) && (addr_i <= A_SHI))
         cls_o = CLS_STS;
      else
         cls_o = CLS_CSR;
   end

endmodule

// File: rtl/hbo_order_unit.sv
module hbo_order_unit #(
   parameter int unsigned WORD_W   = 32,
   parameter bit          IS_WRITE = 1'b1
) (
   input  logic [WORD_W-1:0] din_i,
   input  logic              swap_en_i,
   input  logic              big_en_i,
   output logic [WORD_W-1:0] dout_o
);
   localparam int unsigned HALF = WORD_W / 2;
   localparam int unsigned NB   = WORD_W / 8;

   logic [WORD_W-1:0] rev_in;
   logic [WORD_W-1:0] rev_out;

   // byte reversal network, shared by both variants
   for (genvar b = 0; b < NB; b++) begin : g_rev
      assign rev_out[b*8 +: 8] = rev_in[(NB-1-b)*8 +: 8];
   end

   if (IS_WRITE) begin : g_wr
      // halfword exchange first, byte reversal second
      logic [WORD_W-1:0] s1;
      assign s1     = swap_en_i ? {din_i[HALF-1:0], din_i[WORD_W-1:HALF]} : din_i;
      assign rev_in = s1;
      assign dout_o = big_en_i ? rev_out : s1;
   end else begin : g_rd
      // byte reversal first, halfword exchange second
      logic [WORD_W-1:0] s1;
      assign rev_in = din_i;
      assign s1     = big_en_i ? rev_out : din_i;
      assign dout_o = swap_en_i ? {s1[HALF-1:0], s1[WORD_W-1:HALF]} : s1;
   end

endmodule

// File: rtl/hbo_cfg_regs.sv
module hbo_cfg_regs #(
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned PORT_END_BIT = 20,
   parameter int unsigned SEL_END_BIT  = 21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we_i,
   input  logic              port_bit_i,
   input  logic              sel_bit_i,
   input  logic              swap_we_i,
   input  logic [WORD_W-1:0] swap_raw_i,
   output logic              port_big_o,
   output logic              sel_big_o,
   output logic              swap_en_o,
   output logic [WORD_W-1:0] cfg_word_o,
   output logic [WORD_W-1:0] swap_word_o
);
   logic [WORD_W-1:0] swap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         port_big_o <= 1'b0;
         sel_big_o  <= 1'b0;
         swap_q     <= '0;
      end else begin
         if (cfg_we_i) begin
            port_big_o <= port_bit_i;
            sel_big_o  <= sel_bit_i;
         end
         if (swap_we_i)
            swap_q <= swap_raw_i;
      end
   end

   assign swap_en_o   = &swap_q;
   assign swap_word_o = swap_q;

   always_comb begin
      cfg_word_o               = '0;
      cfg_word_o[PORT_END_BIT] = port_big_o;
      cfg_word_o[SEL_END_BIT]  = sel_big_o;
   end

   // R1: the cycle after reset sees every ordering control cleared
   assert_rst_clears_R1 : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!port_big_o && !sel_big_o && !swap_en_o));

   // R10: the swap register stores the host word untouched
   assert_swap_raw_R10 : assert property (@(posedge clk) disable iff (rst)
      swap_we_i |=> (swap_word_o == $past(swap_raw_i)));

endmodule

// File: rtl/hbus_order_adapter.sv
module hbus_order_adapter
   import hbo_pkg::*;
#(
   parameter int unsigned HALF_W       = 16,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DPORT_TOP    = 'h3C,
   parameter int unsigned STS_LO       = 'h40,
   parameter int unsigned STS_HI       = 'h4C,
   parameter int unsigned CFG_ADDR     = 'h74,
   parameter int unsigned SWAP_ADDR    = 'h98,
   parameter int unsigned PORT_END_BIT = 20,
   parameter int unsigned SEL_END_BIT  = 21
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hb_strobe,
   input  logic                hb_write,
   input  logic                hb_fifo_sel,
   input  logic [ADDR_W-1:0]   hb_addr,
   input  logic [HALF_W-1:0]   hb_wdata,
   output logic [HALF_W-1:0]   hb_rdata,
   output logic                int_wr,
   output logic [ADDR_W-1:0]   int_wr_addr,
   output logic [2*HALF_W-1:0] int_wr_data,
   output logic [1:0]          int_wr_cls,
   output logic                int_rd,
   output logic [ADDR_W-1:0]   int_rd_addr,
   output logic [1:0]          int_rd_cls,
   input  logic [2*HALF_W-1:0] int_rd_data
);
   localparam int unsigned WORD_W = 2 * HALF_W;

   if ((HALF_W % 8) != 0 || HALF_W < 8) begin : g_bad_half
      $error("HALF_W must be a nonzero multiple of 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for word addressing");
   end
   if (PORT_END_BIT >= WORD_W || SEL_END_BIT >= WORD_W || PORT_END_BIT == SEL_END_BIT) begin : g_bad_bits
      $error("endian bit positions must be distinct and inside the word");
   end
   if (CFG_ADDR == SWAP_ADDR) begin : g_bad_map
      $error("configuration and swap registers must not overlap");
   end

   // ---------------- decode of the current cycle ----------------
   acc_cls_t dec_cls;
   logic     dec_cfg, dec_swap;

   hbo_class_decode #(
      .ADDR_W(ADDR_W), .DPORT_TOP(DPORT_TOP), .STS_LO(STS_LO), .STS_HI(STS_HI),
      .CFG_ADDR(CFG_ADDR), .SWAP_ADDR(SWAP_ADDR)
   ) u_dec (
      .addr_i(hb_addr), .fifo_sel_i(hb_fifo_sel),
      .cls_o(dec_cls), .hit_cfg_o(dec_cfg), .hit_swap_o(dec_swap)
   );

   logic hi_half, wr_lo, wr_hi, rd_lo, rd_hi;
   assign hi_half = hb_addr[1];
   assign wr_lo   = hb_strobe &  hb_write & !hi_half;
   assign wr_hi   = hb_strobe &  hb_write &  hi_half;
   assign rd_lo   = hb_strobe & !hb_write & !hi_half;
   assign rd_hi   = hb_strobe & !hb_write &  hi_half;

   logic [ADDR_W-1:0] word_addr;
   assign word_addr = {hb_addr[ADDR_W-1:2], 2'b00};

   // ---------------- configuration state ----------------
   logic              port_big, sel_big, swap_en;
   logic [WORD_W-1:0] cfg_word, swap_word;
   logic              cfg_we, swap_we;
   logic [WORD_W-1:0] wr_raw, wr_ord;

   function automatic logic big_for(input acc_cls_t c, input logic pb, input logic sb);
      return (c == CLS_DPORT) ? pb : ((c == CLS_DSEL) ? sb : 1'b0);
   endfunction

   // ---------------- write assembly ----------------
   logic [HALF_W-1:0] lo_q;
   logic              pend_q, cfg_q, swp_q;
   acc_cls_t          cls_q;
   logic [ADDR_W-1:0] waddr_q;

   assign wr_raw  = {hb_wdata, lo_q};
   assign cfg_we  = wr_hi & pend_q & cfg_q;
   assign swap_we = wr_hi & pend_q & swp_q;

   hbo_order_unit #(.WORD_W(WORD_W), .IS_WRITE(1'b1)) u_wr_order (
      .din_i(wr_raw),
      .swap_en_i(swap_en & !swp_q),
      .big_en_i(big_for(cls_q, port_big, sel_big)),
      .dout_o(wr_ord)
   );

   hbo_cfg_regs #(
      .WORD_W(WORD_W), .PORT_END_BIT(PORT_END_BIT), .SEL_END_BIT(SEL_END_BIT)
   ) u_cfg (
      .clk(clk), .rst(rst),
      .cfg_we_i(cfg_we), .port_bit_i(wr_ord[PORT_END_BIT]), .sel_bit_i(wr_ord[SEL_END_BIT]),
      .swap_we_i(swap_we), .swap_raw_i(wr_raw),
      .port_big_o(port_big), .sel_big_o(sel_big), .swap_en_o(swap_en),
      .cfg_word_o(cfg_word), .swap_word_o(swap_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q        <= '0;
         pend_q      <= 1'b0;
         cfg_q       <= 1'b0;
         swp_q       <= 1'b0;
         cls_q       <= CLS_CSR;
         waddr_q     <= '0;
         int_wr      <= 1'b0;
         int_wr_addr <= '0;
         int_wr_data <= '0;
         int_wr_cls  <= 2'd0;
      end else begin
         int_wr <= 1'b0;
         if (wr_lo) begin
            lo_q    <= hb_wdata;
            pend_q  <= 1'b1;
            cls_q   <= dec_cls;
            cfg_q   <= dec_cfg;
            swp_q   <= dec_swap;
            waddr_q <= word_addr;
         end else if (wr_hi) begin
            pend_q <= 1'b0;
            if (pend_q && !cfg_q && !swp_q) begin
               int_wr      <= 1'b1;
               int_wr_addr <= waddr_q;
               int_wr_data <= wr_ord;
               int_wr_cls  <= 2'(cls_q);
            end
         end
      end
   end

   // ---------------- read split ----------------
   logic [WORD_W-1:0] rd_src, rd_view;
   logic [HALF_W-1:0] rd_hold_hi;

   assign rd_src = dec_swap ? swap_word : (dec_cfg ? cfg_word : int_rd_data);

   hbo_order_unit #(.WORD_W(WORD_W), .IS_WRITE(1'b0)) u_rd_order (
      .din_i(rd_src),
      .swap_en_i(swap_en & !dec_swap),
      .big_en_i(big_for(dec_cls, port_big, sel_big)),
      .dout_o(rd_view)
   );

   assign int_rd      = rd_lo & !dec_cfg & !dec_swap;
   assign int_rd_addr = word_addr;
   assign int_rd_cls  = 2'(dec_cls);

   always_ff @(posedge clk) begin
      if (rst) begin
         hb_rdata   <= '0;
         rd_hold_hi <= '0;
      end else if (rd_lo) begin
         hb_rdata   <= rd_view[HALF_W-1:0];
         rd_hold_hi <= rd_view[WORD_W-1:HALF_W];
      end else if (rd_hi) begin
         hb_rdata   <= rd_hold_hi;
      end
   end

   // R2: an internal write only ever follows an upper-half host write
   assert_wr_after_hi_R2 : assert property (@(posedge clk) disable iff (rst)
      int_wr |-> $past(hb_strobe && hb_write && hb_addr[1]));

   // R7: with no swap, register and status writes keep the host upper half in place
   assert_csr_no_endian_R7 : assert property (@(posedge clk) disable iff (rst)
      (int_wr && (int_wr_cls == 2'd0 || int_wr_cls == 2'd1) && !swap_en)
      |-> (int_wr_data[WORD_W-1:HALF_W] == $past(hb_wdata)));

endmodule

// File: tb/hbus_order_adapter_tb_top.sv
`timescale 1ns/1ps
module hbus_order_adapter_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hb_strobe = 1'b0;
   logic        hb_write = 1'b0;
   logic        hb_fifo_sel = 1'b0;
   logic [7:0]  hb_addr = '0;
   logic [15:0] hb_wdata = '0;
   logic [15:0] hb_rdata;
   logic        int_wr;
   logic [7:0]  int_wr_addr;
   logic [31:0] int_wr_data;
   logic [1:0]  int_wr_cls;
   logic        int_rd;
   logic [7:0]  int_rd_addr;
   logic [1:0]  int_rd_cls;
   logic [31:0] int_rd_data = '0;

   always #2 clk = ~clk;

   hbus_order_adapter dut_i (
      .clk(clk), .rst(rst), .hb_strobe(hb_strobe), .hb_write(hb_write),
      .hb_fifo_sel(hb_fifo_sel), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
      .hb_rdata(hb_rdata), .int_wr(int_wr), .int_wr_addr(int_wr_addr),
      .int_wr_data(int_wr_data), .int_wr_cls(int_wr_cls), .int_rd(int_rd),
      .int_rd_addr(int_rd_addr), .int_rd_cls(int_rd_cls), .int_rd_data(int_rd_data)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   // bench model of the configuration
   bit m_port = 0, m_sel = 0, m_swap = 0;

   // captured results of the latest halfword cycle
   logic        c_rd;  logic [7:0] c_rd_addr; logic [1:0] c_rd_cls;
   logic [15:0] c_rdata;
   logic        c_wr;  logic [31:0] c_wdata; logic [7:0] c_waddr; logic [1:0] c_wcls;

   function automatic logic [31:0] rev32(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction
   function automatic logic [31:0] hsw32(input logic [31:0] x);
      return {x[15:0], x[31:16]};
   endfunction
   function automatic logic [31:0] wr_model(input logic [31:0] w, input bit sw, input bit big);
      logic [31:0] s;
      s = sw ? hsw32(w) : w;
      return big ? rev32(s) : s;
   endfunction
   function automatic logic [31:0] rd_model(input logic [31:0] d, input bit sw, input bit big);
      logic [31:0] e;
      e = big ? rev32(d) : d;
      return sw ? hsw32(e) : e;
   endfunction
   function automatic logic [1:0] cls_of(input bit sel, input logic [7:0] a);
      if (sel) return 2'd3;
      if (a <= 8'h3C) return 2'd2;
      if (a >= 8'h40 && a <= 8'h4C) return 2'd1;
      return 2'd0;
   endfunction
   function automatic bit big_of(input logic [1:0] c);
      return (c == 2'd2) ? m_port : ((c == 2'd3) ? m_sel : 1'b0);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic half(input bit w, input bit sel, input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      hb_strobe = 1'b1; hb_write = w; hb_fifo_sel = sel; hb_addr = a; hb_wdata = d;
      #1;
      c_rd = int_rd; c_rd_addr = int_rd_addr; c_rd_cls = int_rd_cls;
      @(posedge clk);
      #1;
      c_rdata = hb_rdata; c_wr = int_wr; c_wdata = int_wr_data;
      c_waddr = int_wr_addr; c_wcls = int_wr_cls;
      hb_strobe = 1'b0; hb_fifo_sel = 1'b0;
   endtask

   task automatic wr32(input bit s0, input bit s1, input logic [7:0] a,
                       input logic [15:0] h0, input logic [15:0] h1);
      half(1'b1, s0, a, h0);
      half(1'b1, s1, a | 8'h02, h1);
   endtask

   task automatic wr_check(input string req, input bit s0, input bit s1, input logic [7:0] a,
                           input logic [15:0] h0, input logic [15:0] h1);
      logic [1:0] c;
      c = cls_of(s0, a);
      wr32(s0, s1, a, h0, h1);
      chk(req, {31'd0, c_wr}, 32'd1);
      chk(req, c_wdata, wr_model({h1, h0}, m_swap, big_of(c)));
      chk(req, {24'd0, c_waddr}, {24'd0, a});
      chk(req, {30'd0, c_wcls}, {30'd0, c});
   endtask

   task automatic rd_check(input string req, input bit sel, input logic [7:0] a,
                           input logic [31:0] d, input logic [31:0] d2);
      logic [31:0] v;
      logic [1:0]  c;
      c = cls_of(sel, a);
      v = rd_model(d, m_swap, big_of(c));
      int_rd_data = d;
      half(1'b0, sel, a, 16'h0);
      chk(req, {31'd0, c_rd}, 32'd1);
      chk(req, {24'd0, c_rd_addr}, {24'd0, a});
      chk(req, {30'd0, c_rd_cls}, {30'd0, c});
      chk(req, {16'd0, c_rdata}, {16'd0, v[15:0]});
      int_rd_data = d2;
      half(1'b0, sel, a | 8'h02, 16'h0);
      chk(req, {31'd0, c_rd}, 32'd0);
      chk(req, {16'd0, c_rdata}, {16'd0, v[31:16]});
   endtask

   task automatic set_cfg(input bit pb, input bit sb);
      logic [31:0] val, host;
      val  = (32'(pb) << 20) | (32'(sb) << 21);
      host = m_swap ? hsw32(val) : val;
      wr32(1'b0, 1'b0, 8'h74, host[15:0], host[31:16]);
      chk("R10 cfg write not forwarded", {31'd0, c_wr}, 32'd0);
      m_port = pb; m_sel = sb;
   endtask

   task automatic set_swap(input logic [31:0] v);
      wr32(1'b0, 1'b0, 8'h98, v[15:0], v[31:16]);
      chk("R10 swap write not forwarded", {31'd0, c_wr}, 32'd0);
      m_swap = (v == 32'hFFFF_FFFF);
   endtask

   task automatic rd_local(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [15:0] lo;
      half(1'b0, 1'b0, a, 16'h0);
      chk(req, {31'd0, c_rd}, 32'd0);
      lo = c_rdata;
      half(1'b0, 1'b0, a | 8'h02, 16'h0);
      chk(req, {c_rdata, lo}, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] sv;
      void'($urandom(32'd8675309));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1 reset state
      chk("R1 rdata at reset", {16'd0, hb_rdata}, 32'd0);
      chk("R1 int_wr at reset", {31'd0, int_wr}, 32'd0);
      rd_local("R1 cfg cleared", 8'h74, 32'h0);
      rd_local("R1 swap cleared", 8'h98, 32'h0);

      // R2 R4 R5 plain data-port write and read
      wr_check("R2 R4 R5 dport little write", 1'b0, 1'b0, 8'h10, 16'h2211, 16'h4433);
      half(1'b1, 1'b0, 8'h12, 16'hDEAD);
      chk("R2 stray upper half", {31'd0, c_wr}, 32'd0);
      rd_check("R3 R4 dport little read", 1'b0, 8'h3C, 32'hA1B2C3D4, 32'h0BADF00D);

      // R6 R7 R10 port-endian set
      set_cfg(1'b1, 1'b0);
      rd_local("R10 cfg readback", 8'h74, 32'h0010_0000);
      wr_check("R5 R6 dport big write", 1'b0, 1'b0, 8'h00, 16'h2211, 16'h4433);
      chk("R5 byte reversal value", c_wdata, 32'h1122_3344);
      wr_check("R6 dsel stays little", 1'b1, 1'b1, 8'h20, 16'h2211, 16'h4433);
      wr_check("R7 csr no endian", 1'b0, 1'b0, 8'h58, 16'h5566, 16'h7788);
      wr_check("R7 status no endian", 1'b0, 1'b0, 8'h44, 16'h5566, 16'h7788);
      rd_check("R7 status read", 1'b0, 8'h4C, 32'h01020304, 32'h0);

      // R6 select-endian only
      set_cfg(1'b0, 1'b1);
      wr_check("R6 dsel big write", 1'b1, 1'b1, 8'h60, 16'h2211, 16'h4433);
      wr_check("R6 dport little again", 1'b0, 1'b0, 8'h04, 16'h2211, 16'h4433);
      rd_check("R6 dsel big read", 1'b1, 8'h08, 32'h44332211, 32'h0);

      // R11 select change on the upper half
      wr_check("R11 sel dropped mid access", 1'b1, 1'b0, 8'h54, 16'hA0B0, 16'hC0D0);
      chk("R11 sel dropped class", {30'd0, c_wcls}, 32'd3);
      wr_check("R11 sel raised mid access", 1'b0, 1'b1, 8'h54, 16'hA0B0, 16'hC0D0);
      chk("R11 sel raised value", c_wdata, 32'hC0D0_A0B0);

      // R8 R10 swap register
      set_swap(32'hFFFF_FFFE);
      rd_local("R10 swap raw readback", 8'h98, 32'hFFFF_FFFE);
      wr_check("R8 not all ones no swap", 1'b0, 1'b0, 8'h50, 16'hAAAA, 16'hBBBB);
      chk("R8 no swap value", c_wdata, 32'hBBBB_AAAA);
      set_swap(32'hFFFF_FFFF);
      rd_local("R10 swap raw when on", 8'h98, 32'hFFFF_FFFF);
      wr_check("R8 csr swapped", 1'b0, 1'b0, 8'h50, 16'hAAAA, 16'hBBBB);
      chk("R8 swap value", c_wdata, 32'hAAAA_BBBB);
      rd_local("R8 cfg read swapped", 8'h74, 32'h0000_0020);

      // R9 composition with swap and byte reversal
      wr_check("R9 dsel swap+big write", 1'b1, 1'b1, 8'h30, 16'h2211, 16'h4433);
      chk("R9 write value", c_wdata, 32'h3344_1122);
      rd_check("R9 R3 dsel swap+big read", 1'b1, 8'h30, 32'h44332211, 32'hFFFF0000);
      set_cfg(1'b1, 1'b1);
      sv = 32'h0030_0000;
      rd_local("R8 R10 cfg write under swap", 8'h74, hsw32(sv));

      // R1 reset discards partial write and clears state
      half(1'b1, 1'b0, 8'h18, 16'h1234);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      m_port = 0; m_sel = 0; m_swap = 0;
      half(1'b1, 1'b0, 8'h1A, 16'h5678);
      chk("R1 partial write discarded", {31'd0, c_wr}, 32'd0);
      rd_local("R1 cfg after reset", 8'h74, 32'h0);
      rd_local("R1 swap after reset", 8'h98, 32'h0);

      // random mix
      for (int i = 0; i < 120; i++) begin
         int unsigned op, k;
         bit sel;
         logic [7:0] a;
         op = $urandom % 10;
         k  = $urandom % 4;
         sel = 1'b0;
         case (k)
            0: a = 8'(4 * ($urandom % 16));
            1: a = 8'(8'h40 + 4 * ($urandom % 4));
            2: a = 8'(8'h50 + 4 * ($urandom % 8));
            default: begin a = 8'(4 * ($urandom % 64)); sel = 1'b1; end
         endcase
         if (op == 0)
            set_cfg(1'($urandom % 2), 1'($urandom % 2));
         else if (op == 1)
            set_swap(($urandom % 2) ? 32'hFFFF_FFFF : $urandom);
         else if (op < 6)
            wr_check("R9 random write", sel, sel, a, 16'($urandom), 16'($urandom));
         else
            rd_check("R9 random read", sel, a, $urandom, $urandom);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule